// File: doc/BRIEF.md
# Dual-Channel Fetch Address Match Interrupt

This block compares the processor's instruction-fetch address against two programmable 20-bit addresses. When a valid fetch hits an enabled channel, the block raises that channel's request flag for exactly one cycle. A combined request goes straight to the CPU on a path that is never masked, so neither the global interrupt enable nor the current priority level can hold it back. Software uses it to patch code or to stop at a breakpoint.

Software programs the block through a small byte-wide register window. One enable register holds a bit for each channel. Each channel also has a match address split across three bytes. Reads are combinational, and every bit with no function reads as 0. Register writes take effect at the clock edge that samples the write strobe. A fetch in that same cycle is still compared against the previous contents.

Top module: `addr_match_irq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears both enables, both match addresses and any pending request. After that edge `match_req` is 0 and every register byte reads 0.
- R2: The enable register sits at offset 0x09. Bit 0 enables channel 0 and bit 1 enables channel 1. Bits 7:2 ignore writes and read as 0.
- R3: Channel 0's address occupies offsets 0x10, 0x11 and 0x12, and channel 1's occupies 0x14, 0x15 and 0x16. These hold address bits 7:0, 15:8 and 19:16 respectively, with bits 19:16 in the low nibble. The upper nibble of the third byte ignores writes and reads 0. Offsets that are not mapped read 0.
- R4: A valid fetch whose address equals an enabled channel's address sets that channel's bit in `match_req` in the following cycle, for that one cycle only.
- R5: A channel whose enable bit is 0 never requests, even when the address matches.
- R6: When `fetch_valid` is low, no request is produced, whatever `fetch_pc` holds.
- R7: A fetch that is held valid with an unchanged address over several cycles produces only one request pulse.
- R8: If both channels match the same fetch, both `match_req` bits are set and `nmi_src` is 0, meaning channel 0 wins. When only channel 1 requests, `nmi_src` is 1.
- R9: `nmi_req` is high exactly when any `match_req` bit is high. The block has no masking input.
- R10: A fetch in the same cycle as a write to a match address is compared against the address held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| fetch_valid | input | 1 | Fetch address strobe |
| fetch_pc | input | 20 | Instruction fetch address |
| match_req | output | 2 | Per-channel request pulse |
| nmi_req | output | 1 | Combined unmasked request |
| nmi_src | output | 1 | Winning channel of the combined request |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 5-bit register offset, and the channel windows at 0x10 and 0x14 with the enable register at 0x09. With these values every mapped byte can be reached, including the unassigned nibble of each third byte. The comparison can be exercised at the top of the 20-bit range (0xFFFFF) and at zero, the reset value.

// File: rtl/addr_match_irq.sv
module addr_match_irq #(
  parameter int PC_W     = 20,
  parameter int RA_W     = 5,
  parameter int EN_OFS   = 9,
  parameter int BASE_OFS = 16,
  parameter int STRIDE   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [1:0]      match_req,
  output logic            nmi_req,
  output logic            nmi_src
);
  localparam int NCH  = 2;
  localparam int HI_W = PC_W - 16;

  logic [NCH-1:0]           en_q;
  logic [NCH-1:0][PC_W-1:0] addr_q;
  logic                     prev_valid;
  logic [PC_W-1:0]          prev_pc;
  logic                     new_fetch;
  logic [NCH-1:0]           hit;

  assign new_fetch = fetch_valid && !(prev_valid && prev_pc == fetch_pc);

  always_comb begin
    for (int ch = 0; ch < NCH; ch++)
      hit[ch] = new_fetch && en_q[ch] && (addr_q[ch] == fetch_pc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      addr_q     <= '0;
      match_req  <= '0;
      prev_valid <= 1'b0;
      prev_pc    <= '0;
    end else begin
      if (reg_we) begin
        if (reg_addr == RA_W'(EN_OFS)) en_q <= reg_wdata[NCH-1:0];
        for (int ch = 0; ch < NCH; ch++) begin
          if (reg_addr == RA_W'(BASE_OFS + ch*STRIDE))     addr_q[ch][7:0]       <= reg_wdata;
          if (reg_addr == RA_W'(BASE_OFS + ch*STRIDE + 1)) addr_q[ch][15:8]      <= reg_wdata;
          if (reg_addr == RA_W'(BASE_OFS + ch*STRIDE + 2)) addr_q[ch][PC_W-1:16] <= reg_wdata[HI_W-1:0];
        end
      end
      prev_valid <= fetch_valid;
      prev_pc    <= fetch_pc;
      match_req  <= hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_W'(EN_OFS)) reg_rdata[NCH-1:0] = en_q;
    for (int ch = 0; ch < NCH; ch++) begin
      if (reg_addr == RA_W'(BASE_OFS + ch*STRIDE))     reg_rdata         = addr_q[ch][7:0];
      if (reg_addr == RA_W'(BASE_OFS + ch*STRIDE + 1)) reg_rdata         = addr_q[ch][15:8];
      if (reg_addr == RA_W'(BASE_OFS + ch*STRIDE + 2)) reg_rdata[HI_W-1:0] = addr_q[ch][PC_W-1:16];
    end
  end

  assign nmi_req = |match_req;
  assign nmi_src = match_req[1] & ~match_req[0];
endmodule

// File: rtl/addr_match_irq_chk.sv
module addr_match_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       fetch_valid,
  input logic [1:0] match_req,
  input logic       nmi_src,
  input logic [1:0] en_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (match_req == 2'b00 && en_q == 2'b00));

  a_r4_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    $rose(match_req[0]) |-> $past(fetch_valid));

  a_r5_ch0_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_q[0] |=> !match_req[0]);

  a_r5_ch1_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_q[1] |=> !match_req[1]);

  a_r6_no_valid: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> match_req == 2'b00);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    match_req[0] |=> !match_req[0]);

  a_r8_ch0_wins: assert property (@(posedge clk) disable iff (rst)
    match_req == 2'b11 |-> !nmi_src);
endmodule

bind addr_match_irq addr_match_irq_chk u_chk (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid),
  .match_req(match_req), .nmi_src(nmi_src), .en_q(en_q)
);

// File: tb/test_addr_match_irq.sv
module test_addr_match_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [19:0] fetch_pc = '0;
  logic [1:0]  match_req;
  logic        nmi_req;
  logic        nmi_src;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  addr_match_irq i_addr_match_irq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .match_req(match_req), .nmi_req(nmi_req), .nmi_src(nmi_src)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic set_addr(input int ch, input logic [19:0] v);
    wr(5'(16 + 4*ch), v[7:0]);
    wr(5'(17 + 4*ch), v[15:8]);
    wr(5'(18 + 4*ch), {4'h0, v[19:16]});
  endtask

  // one fetch cycle, then sample the request produced by it
  task automatic fetch(input logic [19:0] pc);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 match_req", match_req, 0);
    chk("R1 nmi_req", nmi_req, 0);
    rd("R1 enable", 5'h09, 8'h00);
    rd("R1 addr0 lo", 5'h10, 8'h00);
    rd("R1 addr1 hi", 5'h16, 8'h00);
  endtask

  task automatic t_regmap;
    wr(5'h09, 8'hFF);
    rd("R2 enable upper bits", 5'h09, 8'h03);
    wr(5'h09, 8'h00);
    rd("R2 enable clear", 5'h09, 8'h00);
    set_addr(0, 20'hA5C3E);
    wr(5'h12, 8'hFA);
    rd("R3 ch0 byte0", 5'h10, 8'h3E);
    rd("R3 ch0 byte1", 5'h11, 8'h5C);
    rd("R3 ch0 byte2 nibble", 5'h12, 8'h0A);
    set_addr(1, 20'h1B2C4);
    rd("R3 ch1 byte0", 5'h14, 8'hC4);
    rd("R3 ch1 byte1", 5'h15, 8'hB2);
    rd("R3 ch1 byte2", 5'h16, 8'h01);
    wr(5'h13, 8'h77);
    rd("R3 unmapped", 5'h13, 8'h00);
    rd("R3 ch0 intact", 5'h12, 8'h0A);
  endtask

  task automatic t_disabled;
    fetch(20'hA5C3E);
    chk("R5 disabled ch0", match_req, 2'b00);
    @(negedge clk);
  endtask

  task automatic t_match;
    wr(5'h09, 8'h01);
    fetch(20'hA5C3E);
    chk("R4 ch0 pulse", match_req, 2'b01);
    chk("R9 combined", nmi_req, 1);
    chk("R8 src ch0", nmi_src, 0);
    @(negedge clk);
    chk("R4 pulse ends", match_req, 2'b00);
    fetch(20'hA5C3F);
    chk("R4 near miss", match_req, 2'b00);
    @(negedge clk);
  endtask

  task automatic t_novalid;
    fetch_pc = 20'hA5C3E; fetch_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 no valid", match_req, 2'b00);
    chk("R9 idle", nmi_req, 0);
  endtask

  task automatic t_stall;
    fetch_valid = 1'b1; fetch_pc = 20'hA5C3E;
    @(negedge clk);
    chk("R7 first", match_req, 2'b01);
    @(negedge clk);
    chk("R7 held 1", match_req, 2'b00);
    @(negedge clk);
    chk("R7 held 2", match_req, 2'b00);
    fetch_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_both;
    wr(5'h09, 8'h03);
    set_addr(1, 20'hA5C3E);
    fetch(20'hA5C3E);
    chk("R8 both flags", match_req, 2'b11);
    chk("R8 src ch0 wins", nmi_src, 0);
    chk("R9 both", nmi_req, 1);
    @(negedge clk);
    set_addr(1, 20'hFFFFF);
    fetch(20'hFFFFF);
    chk("R8 ch1 only", match_req, 2'b10);
    chk("R8 src ch1", nmi_src, 1);
    @(negedge clk);
    set_addr(0, 20'h00000);
    fetch(20'h00000);
    chk("R4 zero address", match_req, 2'b01);
    @(negedge clk);
  endtask

  task automatic t_same_cycle;
    set_addr(0, 20'h12345);
    reg_we = 1'b1; reg_addr = 5'h10; reg_wdata = 8'h99;
    fetch_valid = 1'b1; fetch_pc = 20'h12345;
    @(negedge clk);
    reg_we = 1'b0; fetch_valid = 1'b0;
    chk("R10 old value used", match_req[0], 1);
    @(negedge clk);
    fetch(20'h12399);
    chk("R10 new value", match_req[0], 1);
    @(negedge clk);
  endtask

  task automatic t_reset_again;
    wr(5'h09, 8'h03);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd("R1 enable after reset", 5'h09, 8'h00);
    rd("R1 addr after reset", 5'h10, 8'h00);
    fetch(20'h00000);
    chk("R1 no request after reset", match_req, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_disabled();
    t_match();
    t_novalid();
    t_stall();
    t_both();
    t_same_cycle();
    t_reset_again();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule